// File: doc/BRIEF.md
# Bit-Timed Serial Byte Shifter

This block is the master end of a three-wire serial link. It moves one byte per request, either out on the data-out line or in from the data-in line, while it generates the serial clock itself. Each serial clock bit is a high phase followed by a low phase. Each phase lasts `HALF_CYCLES` system clock cycles, which sets the bit rate against the system clock.

A send and a receive use different phase timing. On a send, the clock rises first and the outgoing bit is placed on data-out one system cycle later. It is then held through the rest of the bit, so the far end can take it on the falling clock edge. On a receive, the data-in line passes through a synchroniser of `SYNC_STAGES` flops. The capture point is moved later by the same number of cycles, so the stored bit is the line level in the last cycle before the clock falls. A send ignores data-in. A receive holds data-out at 0. At the end of the eighth low phase a one-cycle done pulse is raised, and a request present in that cycle is taken at once.

`HALF_CYCLES` must be at least `SYNC_STAGES` (the default is 2 stages) and at least 2.

Top module: `spi_byte_shifter`

## Requirements
- R1: During and after reset, with no request given, sck, mosi and done are 0 and rxByte is 0x00.
- R2: A send shifts txByte out most significant bit first, one bit per clock pulse. The mosi level at each falling sck edge is the next bit. A send leaves rxByte unchanged whatever miso does.
- R3: During a send, mosi never changes in the cycle in which sck rises. Each new bit appears one system cycle after the rise. Sampled in the first high cycle of bit k, mosi still shows the previous bit, with 0 before bit 7. The eight such samples, taken in order, form txByte shifted right by one.
- R4: Every byte has exactly eight sck high pulses. Each high phase and each low phase lasts HALF_CYCLES system cycles.
- R5: A receive stores the miso level present in the last cycle before each falling sck edge, most significant bit first. It shows the byte on rxByte from the done cycle onward and keeps it until the next receive completes. mosi stays 0 for the whole receive.
- R6: If a request is taken at clock edge E0, done is 1 for exactly the one cycle that starts at edge E0 + 16*HALF_CYCLES. In that cycle sck and mosi are 0.
- R7: A send or receive request, together with any txByte change, given while a byte is in progress has no effect on the current byte or its timing.
- R8: When sendReq and recvReq are both 1 in the same idle cycle, a send is performed and rxByte is unchanged.
- R9: A request present in the done cycle is taken at the edge that ends it. sck rises in the very next cycle, so a held request runs bytes back to back: the second done starts 16*HALF_CYCLES + 1 edges after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sendReq | input | 1 | Request to transmit txByte; taken when idle |
| recvReq | input | 1 | Request to receive one byte; taken when idle |
| txByte | input | DATA_W | Byte to transmit, captured when a send is taken |
| miso | input | 1 | Serial data in, asynchronous to clk |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| rxByte | output | DATA_W | Last byte received |
| done | output | 1 | One-cycle pulse at the end of each byte |

## Verification
Two things can fall in the same cycle: the done pulse that ends one byte, and the acceptance of the next request. The bench provokes this by holding sendReq high across a whole byte. The request is ignored while the byte runs and must be taken in the done cycle. The check is that the second done arrives exactly 16*HALF_CYCLES + 1 edges after the first, with sixteen clock pulses in all and an unchanged bit pattern. The other same-cycle case, a send and a receive requested together, is judged by a send pattern appearing on mosi and by rxByte not moving.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  // Strobes issued by the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic load;      // a request is being taken this cycle
    logic loadRecv;  // the taken request is a receive
    logic shiftTx;   // drive the next outgoing bit at the coming edge
    logic sampleRx;  // capture the synchronised input bit at the coming edge
    logic finish;    // last low phase ends at the coming edge
  } shStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } shPhase_e;

endpackage

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sendReq,
  input  logic      recvReq,
  output logic      sck,
  output logic      done,
  output logic      recvMode,
  output shStrobe_t stb
);

  localparam int CW  = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0]  PH_LAST   = CW'(HALF_CYCLES - 1);
  localparam logic [CW-1:0]  SAMPLE_AT = CW'(SYNC_STAGES - 1);
  localparam logic [BCW-1:0] BIT_LAST  = BCW'(DATA_W - 1);

  shPhase_e       phase;
  logic [CW-1:0]  phaseCnt;
  logic [BCW-1:0] bitCnt;
  logic           phaseEnd;

  assign phaseEnd = (phaseCnt == PH_LAST);

  always_comb begin
    stb          = '0;
    stb.load     = (phase == PH_IDLE) && (sendReq || recvReq);
    stb.loadRecv = recvReq && !sendReq;
    stb.shiftTx  = (phase == PH_HIGH) && (phaseCnt == '0) && !recvMode;
    stb.sampleRx = (phase == PH_LOW) && (phaseCnt == SAMPLE_AT) && recvMode;
    stb.finish   = (phase == PH_LOW) && phaseEnd && (bitCnt == BIT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      sck      <= 1'b0;
      done     <= 1'b0;
      recvMode <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (stb.load) begin
            phase    <= PH_HIGH;
            sck      <= 1'b1;
            phaseCnt <= '0;
            bitCnt   <= '0;
            recvMode <= stb.loadRecv;
          end
        end
        PH_HIGH: begin
          if (phaseEnd) begin
            phase    <= PH_LOW;
            sck      <= 1'b0;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_LOW: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (bitCnt == BIT_LAST) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              phase  <= PH_HIGH;
              sck    <= 1'b1;
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shStrobe_t         stb,
  input  logic              recvMode,
  input  logic [DATA_W-1:0] txByte,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxByte
);

  logic [DATA_W-1:0]      txSh;
  logic [DATA_W-1:0]      rxSh;
  logic [DATA_W-1:0]      rxNext;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   misoSync;

  // Input synchroniser chain, one flop per stage.
  genvar gs;
  generate
    for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
      if (gs == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[0] <= 1'b0;
          else        syncQ[0] <= miso;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[gs] <= 1'b0;
          else        syncQ[gs] <= syncQ[gs-1];
        end
      end
    end
  endgenerate

  assign misoSync = syncQ[SYNC_STAGES-1];
  assign rxNext   = stb.sampleRx ? {rxSh[DATA_W-2:0], misoSync} : rxSh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txSh   <= '0;
      rxSh   <= '0;
      mosi   <= 1'b0;
      rxByte <= '0;
    end else begin
      if (stb.load) begin
        txSh <= stb.loadRecv ? '0 : txByte;
        rxSh <= '0;
      end else begin
        if (stb.shiftTx) begin
          mosi <= txSh[DATA_W-1];
          txSh <= {txSh[DATA_W-2:0], 1'b0};
        end
        rxSh <= rxNext;
        if (stb.finish) begin
          mosi <= 1'b0;
          if (recvMode) rxByte <= rxNext;
        end
      end
    end
  end

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sendReq,
  input  logic              recvReq,
  input  logic [DATA_W-1:0] txByte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rxByte,
  output logic              done
);

  shStrobe_t stb;
  logic      recvMode;

  spi_shift_ctrl #(
    .DATA_W(DATA_W), .HALF_CYCLES(HALF_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .sendReq(sendReq), .recvReq(recvReq),
    .sck(sck), .done(done), .recvMode(recvMode), .stb(stb)
  );

  spi_shift_dp #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .recvMode(recvMode),
    .txByte(txByte), .miso(miso), .mosi(mosi), .rxByte(rxByte)
  );

endmodule

// File: rtl/spi_byte_shifter_chk.sv
module spi_byte_shifter_chk #(
  parameter int DATA_W      = 8,
  parameter int HALF_CYCLES = 500
) (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic mosi,
  input logic done,
  input logic recvMode
);

  localparam int RCW = $clog2(DATA_W + 1);

  int             hiCnt;
  logic [RCW-1:0] riseCnt;
  logic           sckQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiCnt   <= 0;
      riseCnt <= '0;
      sckQ    <= 1'b0;
    end else begin
      sckQ  <= sck;
      hiCnt <= sck ? hiCnt + 1 : 0;
      if (done)              riseCnt <= '0;
      else if (sck && !sckQ) riseCnt <= riseCnt + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sck && !mosi)); // R6

  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hiCnt == HALF_CYCLES)); // R4

  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (riseCnt == RCW'(DATA_W))); // R4

  AST_MOSI_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi)); // R3

  AST_RECV_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    recvMode |-> !mosi); // R5

endmodule

bind spi_byte_shifter spi_byte_shifter_chk #(
  .DATA_W(DATA_W), .HALF_CYCLES(HALF_CYCLES)
) uChk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .done(done),
  .recvMode(recvMode)
);

// File: tb/sim_spi_byte_shifter.sv
module sim_spi_byte_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int BYTE_EDGES = 16 * HALF;
  localparam int NVEC       = 8;
  // Each entry: {isReceive, dataByte}
  localparam logic [8:0] VECS [NVEC] = '{
    9'h0A5, 9'h001, 9'h080, 9'h13C, 9'h1FF, 9'h100, 9'h0FF, 9'h196
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sendReq = 1'b0;
  logic       recvReq = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       miso = 1'b0;
  logic       sck, mosi, done;
  logic [7:0] rxByte;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // monitor state
  logic [7:0] misoByte = 8'h00;
  logic [7:0] fallByte = 8'h00;
  logic [7:0] riseByte = 8'h00;
  int         riseTotal = 0;
  logic       prevSck = 1'b0;
  logic       lastMosi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_shifter #(.DATA_W(8), .HALF_CYCLES(HALF), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sendReq(sendReq), .recvReq(recvReq),
    .txByte(txByte), .miso(miso), .sck(sck), .mosi(mosi),
    .rxByte(rxByte), .done(done)
  );

  // Far-end model: changes miso at the first high cycle of each bit,
  // records mosi at each rise and just before each fall.
  always @(negedge clk) begin
    if (sck && !prevSck) begin
      riseByte = {riseByte[6:0], mosi};
      miso = misoByte[3'd7 - 3'(riseTotal)];
      riseTotal = riseTotal + 1;
    end
    if (sck) lastMosi = mosi;
    if (!sck && prevSck) fallByte = {fallByte[6:0], lastMosi};
    prevSck = sck;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Run one byte. both: raise both requests. intrude: pulse requests mid-byte.
  task automatic runByte(input bit recv, input logic [7:0] val,
                         input bit both, input bit intrude);
    int n;
    int riseStart;
    logic [7:0] rxBefore;
    bit doSend;
    doSend    = both || !recv;
    misoByte  = doSend ? (val ^ 8'h5A) : val;
    rxBefore  = rxByte;
    riseStart = riseTotal;
    @(negedge clk);
    txByte  = val;
    sendReq = doSend;
    recvReq = recv || both;
    @(negedge clk);
    sendReq = 1'b0;
    recvReq = 1'b0;
    n = 1;
    while (!done && n < 4 * BYTE_EDGES) begin
      @(negedge clk);
      n++;
      if (intrude && n == 20) begin
        sendReq = 1'b1; recvReq = 1'b1; txByte = ~val;
      end else if (intrude && n == 21) begin
        sendReq = 1'b0; recvReq = 1'b0;
      end
    end
    chk(n == BYTE_EDGES + 1, intrude ? "R7 timing" : "R6 done timing", n, BYTE_EDGES + 1);
    chk(!sck && !mosi, "R6 lines low at done", {sck, mosi}, 0);
    chk(riseTotal - riseStart == 8, "R4 pulse count", riseTotal - riseStart, 8);
    if (doSend) begin
      chk(fallByte == val, both ? "R8 send chosen" : (intrude ? "R7 data" : "R2 mosi at fall"), fallByte, val);
      chk(riseByte == (val >> 1), "R3 mosi at rise", riseByte, val >> 1);
      chk(rxByte == rxBefore, both ? "R8 rxByte kept" : "R2 rxByte kept", rxByte, rxBefore);
    end else begin
      chk(rxByte == val, "R5 received byte", rxByte, val);
      chk(fallByte == 8'h00, "R5 mosi low in receive", fallByte, 0);
    end
    @(negedge clk);
    chk(!done, "R6 done single cycle", done, 0);
    if (!doSend) chk(rxByte == val, "R5 rxByte held", rxByte, val);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int riseStart;
    repeat (3) @(negedge clk);
    chk({sck, mosi, done} == 3'b000 && rxByte == 8'h00, "R1 in reset", {sck, mosi, done, rxByte}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({sck, mosi, done} == 3'b000 && rxByte == 8'h00, "R1 after reset", {sck, mosi, done, rxByte}, 0);

    for (int i = 0; i < NVEC; i++) begin
      runByte(VECS[i][8], VECS[i][7:0], 1'b0, 1'b0);
    end

    // R7: requests and txByte change in the middle of a send and a receive
    runByte(1'b0, 8'hC3, 1'b0, 1'b1);
    runByte(1'b1, 8'h69, 1'b0, 1'b1);

    // R8: both requests together
    runByte(1'b1, 8'h4E, 1'b1, 1'b0);

    // R9: held request, done and acceptance in the same cycle
    misoByte  = 8'h00;
    riseStart = riseTotal;
    @(negedge clk);
    txByte  = 8'hB2;
    sendReq = 1'b1;
    @(negedge clk);
    n = 1;
    while (!done && n < 4 * BYTE_EDGES) begin @(negedge clk); n++; end
    chk(n == BYTE_EDGES + 1, "R9 first done", n, BYTE_EDGES + 1);
    @(negedge clk);
    n++;
    chk(sck == 1'b1, "R9 immediate restart", sck, 1);
    while (!done && n < 8 * BYTE_EDGES) begin @(negedge clk); n++; end
    sendReq = 1'b0;
    chk(n == 2 * BYTE_EDGES + 2, "R9 second done", n, 2 * BYTE_EDGES + 2);
    chk(riseTotal - riseStart == 16, "R9 pulse count", riseTotal - riseStart, 16);
    chk(fallByte == 8'hB2, "R9 second byte data", fallByte, 8'hB2);
    repeat (2 * BYTE_EDGES) @(negedge clk);
    chk(!sck && !done, "R9 idle after release", {sck, done}, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule